// File: doc/BRIEF.md
# Link-Change Wake Event Logic

This block drives the power-management event (PME) pin of a network controller while it sleeps. It keeps a sticky "link change seen" flag. The flag is set by a one-cycle pulse from the management polling logic, but only when link-change wake mode is enabled. The block combines that flag with a magic-packet match input. The result goes through a PME enable bit and an enable-override bit, and a register drives the active-high PME pin.

Software sees a 16-bit control/status word through a simple write strobe and a 32-bit read bus. The link-change flag is write-1-to-clear. Every other implemented bit is plain read/write storage. A warm reset returns the stored bits to their initial value. Only power-on reset clears the link-change flag, so a wake cause survives a warm restart of the controller.

Bit positions that software depends on:

- Bit 4: PME enable.
- Bit 8: link-change wake mode.
- Bit 9: link-change seen flag.
- Bit 10: override.

Top module: `lnk_wake_pme`

## Requirements
- R1: While `por_n` is low and after its release, `rd_data` reads the initial value `CFG_INIT` (default 0), with bit 9 at 0, and `pme` is 0.
- R2: A cycle with `link_chg`=1 while bit 8 (wake mode) reads 1 sets bit 9 at that clock edge.
- R3: A `link_chg` pulse while bit 8 reads 0 has no effect: bit 9 stays 0.
- R4: A write with `wr_data[9]`=1 clears bit 9, and a write with `wr_data[9]`=0 leaves bit 9 unchanged.
- R5: When a qualified link pulse and a clearing write to bit 9 fall in the same cycle, bit 9 ends up set.
- R6: With bit 10 at 0, `pme` is 1 exactly when bit 4 is 1 and either `magic_hit` or bit 9 is 1.
- R7: With bit 10 at 1, `pme` is 1 whenever `magic_hit` or bit 9 is 1, whatever bit 4 holds.
- R8: `pme` is registered: it follows a change of its inputs one clock edge later.
- R9: `warm_rst` loads every stored bit except bit 9 with `CFG_INIT`, and bit 9 keeps its value.
- R10: `rd_data[31:16]` always reads 0.
- R11: Every bit of the 16-bit word other than bit 9 reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset of the stored bits, active high |
| link_chg | input | 1 | One-cycle link-status change pulse |
| magic_hit | input | 1 | Magic-packet match flag |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 32 | Read-back of the control/status word |
| pme | output | 1 | Power-management event output, active high |

## Verification
A wrong flag or mode bit shows up on `rd_data` bit 9 at the first sample after the edge that should have changed it. A wrong gating of enable, override, flag and match shows up on `pme` exactly two edges after the write that set the control bits, or one edge after `magic_hit` changes. All sixteen combinations of override, enable, match and flag are swept, so a gating error cannot hide behind an untried combination. The corner cases are tested in the cycle they occur: a link pulse colliding with a clearing write, and a warm reset while the flag is set.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int EN_BIT   = 4;
    localparam int MODE_BIT = 8;
    localparam int DET_BIT  = 9;
    localparam int OVR_BIT  = 10;
endpackage

// File: rtl/wake_cfg_reg.sv
module wake_cfg_reg
    import wake_pkg::*;
#(
    parameter int              CFG_W    = 16,
    parameter logic [CFG_W-1:0] CFG_INIT = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q
);
    localparam logic [CFG_W-1:0] KEEP_MASK = ~(CFG_W'(1) << DET_BIT);

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (warm_rst) begin
            st_d.word = CFG_INIT & KEEP_MASK;
        end else if (wr_en) begin
            st_d.word = wr_data & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{word: CFG_INIT & KEEP_MASK};
        else        st_q <= st_d;
    end

    assign cfg_q = st_q.word;

    // R9: warm reset restores the initial value
    a_r9_warm_restore: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |=> (cfg_q == (CFG_INIT & KEEP_MASK)));
    // R11: a write outside warm reset is stored
    a_r11_write_kept: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !warm_rst) |=> (cfg_q == ($past(wr_data) & KEEP_MASK)));
endmodule

// File: rtl/wake_link_det.sv
module wake_link_det (
    input  logic clk,
    input  logic por_n,
    input  logic link_chg,
    input  logic mode,
    input  logic clr_wr,
    output logic det_q
);
    typedef struct packed {
        logic det;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr)            st_d.det = 1'b0;
        if (link_chg && mode)  st_d.det = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{det: 1'b0};
        else        st_q <= st_d;
    end

    assign det_q = st_q.det;

    // R2 and R5: a qualified pulse always leaves the flag set
    a_r2_set_on_pulse: assert property (@(posedge clk) disable iff (!por_n)
        (link_chg && mode) |=> det_q);
    // R3: the flag rises only after a qualified pulse
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!por_n)
        $rose(det_q) |-> $past(link_chg && mode));
    // R4: a clearing write without a pulse drops the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (!por_n)
        (clr_wr && !(link_chg && mode)) |=> !det_q);
endmodule

// File: rtl/wake_pme_drv.sv
module wake_pme_drv (
    input  logic clk,
    input  logic por_n,
    input  logic det,
    input  logic magic_hit,
    input  logic pme_en,
    input  logic ovr,
    output logic pme_q
);
    typedef struct packed {
        logic pme;
    } pme_state_t;

    pme_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pme = (magic_hit || det) && (pme_en || ovr);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{pme: 1'b0};
        else        st_q <= st_d;
    end

    assign pme_q = st_q.pme;
endmodule

// File: rtl/lnk_wake_pme.sv
module lnk_wake_pme
    import wake_pkg::*;
#(
    parameter int               CFG_W    = 16,
    parameter int               BUS_W    = 32,
    parameter logic [CFG_W-1:0] CFG_INIT = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst,
    input  logic             link_chg,
    input  logic             magic_hit,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    output logic             pme
);
    logic [CFG_W-1:0] cfg_q;
    logic             det_q;
    logic             clr_wr;

    assign clr_wr = wr_en && wr_data[DET_BIT];

    wake_cfg_reg #(.CFG_W(CFG_W), .CFG_INIT(CFG_INIT)) u_cfg (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q)
    );

    wake_link_det u_det (
        .clk(clk), .por_n(por_n), .link_chg(link_chg),
        .mode(cfg_q[MODE_BIT]), .clr_wr(clr_wr), .det_q(det_q)
    );

    wake_pme_drv u_pme (
        .clk(clk), .por_n(por_n), .det(det_q), .magic_hit(magic_hit),
        .pme_en(cfg_q[EN_BIT]), .ovr(cfg_q[OVR_BIT]), .pme_q(pme)
    );

    always_comb begin
        rd_data                = '0;
        rd_data[CFG_W-1:0]     = cfg_q;
        rd_data[DET_BIT]       = det_q;
    end

    // R7: override forces the pin on a pending wake cause
    a_r7_override: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_q[OVR_BIT] && (magic_hit || det_q)) |=> pme);
    // R6: with neither enable nor override the pin stays low
    a_r6_gated_off: assert property (@(posedge clk) disable iff (!por_n)
        !(cfg_q[EN_BIT] || cfg_q[OVR_BIT]) |=> !pme);
    // R8: no wake cause on the previous edge means no pin
    a_r8_one_edge: assert property (@(posedge clk) disable iff (!por_n)
        !(magic_hit || det_q) |=> !pme);
    // R10: upper read bits stay zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[BUS_W-1:CFG_W] == '0);
endmodule

// File: tb/lnk_wake_pme_test.sv
`timescale 1ns/1ps
module lnk_wake_pme_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        link_chg = 1'b0;
    logic        magic_hit = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pme;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lnk_wake_pme uut (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .link_chg(link_chg),
        .magic_hit(magic_hit), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pme(pme)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse();
        link_chg = 1'b1;
        step();
        link_chg = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        step(2);
        chk("R1 rd in reset", rd_data, 32'h0);
        chk("R1 pme in reset", {31'h0, pme}, 32'h0);
        por_n = 1'b1;
        step(2);
        chk("R1 rd after reset", rd_data, 32'h0);
        chk("R1 pme after reset", {31'h0, pme}, 32'h0);

        // R3: pulse with mode off
        pulse();
        chk("R3 pulse ignored", {31'h0, rd_data[9]}, 32'h0);

        // R2: mode on, pulse sets flag
        wr(16'h0100);
        pulse();
        chk("R2 flag set", {31'h0, rd_data[9]}, 32'h1);
        // R4: write 0 at bit 9 keeps flag
        wr(16'h0100);
        chk("R4 write0 keeps", {31'h0, rd_data[9]}, 32'h1);
        wr(16'h0300);
        chk("R4 write1 clears", {31'h0, rd_data[9]}, 32'h0);
        // R5: collision
        link_chg = 1'b1; wr(16'h0300); link_chg = 1'b0;
        chk("R5 pulse wins", {31'h0, rd_data[9]}, 32'h1);

        // R6 / R7 sweep over override, enable, match, flag
        for (int c = 0; c < 16; c++) begin
            bit o, e, m, d, exp_p;
            o = c[3]; e = c[2]; m = c[1]; d = c[0];
            wr({5'b0, o, 2'b11, 3'b0, e, 4'b0});
            if (d) pulse();
            magic_hit = m;
            step(2);
            exp_p = (m | d) & (e | o);
            chk(o ? "R7 pme override" : "R6 pme gated", {31'h0, pme}, {31'h0, exp_p});
            magic_hit = 1'b0;
            step();
        end

        // R8: one-edge latency of pme
        wr(16'h0310);
        step(2);
        chk("R8 pme idle", {31'h0, pme}, 32'h0);
        magic_hit = 1'b1;
        #0;
        chk("R8 pme not yet", {31'h0, pme}, 32'h0);
        step();
        chk("R8 pme one edge later", {31'h0, pme}, 32'h1);
        magic_hit = 1'b0;
        step();
        chk("R8 pme drops one edge later", {31'h0, pme}, 32'h0);

        // R9: warm reset keeps the flag
        wr(16'hFDFF);
        pulse();
        warm_rst = 1'b1; step(); warm_rst = 1'b0;
        chk("R9 warm keeps flag", rd_data, 32'h0000_0200);

        // R11 / R10: read-back patterns
        for (int k = 0; k < 4; k++) begin
            logic [15:0] v;
            v = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'hA5A5 : 16'h5A5A;
            wr(v | 16'h0200);
            chk("R11 readback", {16'h0, rd_data[15:0]}, {16'h0, v & 16'hFDFF});
            chk("R10 upper zero", {16'h0, rd_data[31:16]}, 32'h0);
        end
        finish_run();
    end
endmodule